// File: doc/BRIEF.md
# Set-Associative Write-Back Cache

This block sits between a processor that issues single-word loads and stores and a slower memory that moves whole blocks. It holds a configurable number of sets, each with a configurable number of ways, and each way holds one block of several words. Every way carries a tag, a valid flag, a dirty flag and a small age value that ranks the ways of its set by recency.

A hit is answered from the cache one cycle after the request is taken. A miss stalls the processor port. If the chosen victim holds modified data, the block writes that victim back first. It then fetches the missing block and completes the original load or store against the fetched data. Stores always allocate. Free-running counters track hits, misses and write-backs. A live count reports how many valid lines are still dirty.

Top module: `wb_cache`

## Requirements
- R1: A word address splits as offset = bits [OFF_W-1:0], set = the next SET_W bits, tag = the remaining upper bits. A block transfer on the memory side always carries the block base address, with the offset bits set to zero. With the defaults this is offset [1:0], set [3:2] and tag [15:4].
- R2: On a read hit, `cpu_rvalid` is high for exactly one cycle, one cycle after acceptance, with the stored word on `cpu_rdata`. There is no memory traffic and `cpu_ready` stays high.
- R3: A miss whose victim is invalid or clean causes exactly one memory read (`mem_we` = 0) of the requested block and no memory write. The requested word is then returned.
- R4: A write miss fetches the block, merges the written word into it and leaves the line dirty. The other words of the block keep the fetched values.
- R5: A write hit updates the word, marks the line dirty and causes no memory traffic.
- R6: When the victim is dirty, a memory write (`mem_we` = 1) of the whole victim block to the victim's base address completes before the fill read starts. While `mem_ready` is low, the memory request, address and direction hold steady.
- R7: A miss in a set that still has an invalid way evicts no valid line.
- R8: On a miss in a full set, the least recently accessed way is replaced. Every access makes its way the most recent.
- R9: `cpu_ready` is low from the cycle after a miss is accepted until the fill completes. No request is taken in that window.
- R10: `hit_cnt`, `miss_cnt` and `wb_cnt` each grow by one per hit, miss and completed write-back. `dirty_lines` equals the number of valid lines holding modified data.
- R11: After reset `cpu_ready` is high, `mem_req` and `cpu_rvalid` are low, all counters read zero and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | Request is taken when cpu_req and cpu_ready are both high at a clock edge |
| cpu_rvalid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Load data, or the stored word for a store |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | ADDR_W | Block base word address |
| mem_wdata | output | BLK_WORDS*WORD_W | Victim block, word 0 in the low bits |
| mem_ready | input | 1 | Transfer completes at an edge where mem_req and mem_ready are both high |
| mem_rdata | input | BLK_WORDS*WORD_W | Fill block, valid with mem_ready |
| hit_cnt | output | CNT_W | Hit count |
| miss_cnt | output | CNT_W | Miss count |
| wb_cnt | output | CNT_W | Write-back count |
| dirty_lines | output | CNT_W | Valid dirty lines right now |

## Verification
A corrupted age ranking stays hidden until a full set misses. At that point the wrong block leaves the cache. This shows up as a write-back to an unexpected address, or as a later miss on a block that should have hit. A dropped dirty flag shows up as a missing memory write on the next eviction of that line and as a low `dirty_lines`. A wrong tag or data word shows up on the very next load of that address. The directed cases therefore force evictions with known recency orders and reload the evicted blocks, so that each of these faults reaches the ports within a few accesses.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } wbc_state_e;
endpackage

// File: rtl/wbc_lookup.sv
module wbc_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 12,
  parameter int WAY_W = 1
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       valid,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wbc_victim.sv
module wbc_victim #(
  parameter int WAYS  = 2,
  parameter int AGE_W = 1
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic [AGE_W-1:0]      victim
);
  logic found;

  always_comb begin
    victim = '0;
    found  = 1'b0;
    // free ways first, lowest index wins
    for (int w = 0; w < WAYS; w++) begin
      if (!valid[w] && !found) begin
        victim = AGE_W'(w);
        found  = 1'b1;
      end
    end
    // otherwise the oldest way
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages[w*AGE_W +: AGE_W] == AGE_W'(WAYS-1)) victim = AGE_W'(w);
      end
    end
  end
endmodule

// File: rtl/wbc_age_update.sv
module wbc_age_update #(
  parameter int WAYS  = 2,
  parameter int AGE_W = 1
) (
  input  logic [WAYS*AGE_W-1:0] ages_in,
  input  logic [AGE_W-1:0]      acc_way,
  output logic [WAYS*AGE_W-1:0] ages_out
);
  logic [AGE_W-1:0] old_age;

  always_comb begin
    old_age  = ages_in[int'(acc_way)*AGE_W +: AGE_W];
    ages_out = ages_in;
    for (int w = 0; w < WAYS; w++) begin
      if (AGE_W'(w) == acc_way) begin
        ages_out[w*AGE_W +: AGE_W] = '0;
      end else if (ages_in[w*AGE_W +: AGE_W] < old_age) begin
        ages_out[w*AGE_W +: AGE_W] = ages_in[w*AGE_W +: AGE_W] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbc_dirty_count.sv
module wbc_dirty_count #(
  parameter int LINES = 8,
  parameter int CNT_W = 16
) (
  input  logic [LINES-1:0] valid,
  input  logic [LINES-1:0] dirty,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < LINES; i++) begin
      count = count + CNT_W'(valid[i] & dirty[i]);
    end
  end
endmodule

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [WORD_W-1:0]           cpu_wdata,
  output logic                        cpu_ready,
  output logic                        cpu_rvalid,
  output logic [WORD_W-1:0]           cpu_rdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [BLK_WORDS*WORD_W-1:0] mem_wdata,
  input  logic                        mem_ready,
  input  logic [BLK_WORDS*WORD_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]            hit_cnt,
  output logic [CNT_W-1:0]            miss_cnt,
  output logic [CNT_W-1:0]            wb_cnt,
  output logic [CNT_W-1:0]            dirty_lines
);
  import wbc_pkg::*;

  localparam int OFF_W  = $clog2(BLK_WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int AGE_W  = WAY_W;
  localparam int LINE_W = BLK_WORDS * WORD_W;
  localparam int LINES  = SETS * WAYS;

  function automatic logic [WAYS*AGE_W-1:0] age_init();
    logic [WAYS*AGE_W-1:0] r;
    for (int w = 0; w < WAYS; w++) r[w*AGE_W +: AGE_W] = AGE_W'(w);
    return r;
  endfunction

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  // storage
  logic [WAYS*TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0]        vld_q [SETS];
  logic [WAYS-1:0]        dty_q [SETS];
  logic [WAYS*AGE_W-1:0]  age_q [SETS];
  logic [LINE_W-1:0]      line_q [SETS][WAYS];

  // control state
  wbc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic [WAY_W-1:0]  vic_q;
  logic              rvalid_q;
  logic [WORD_W-1:0] rdata_q;
  logic [CNT_W-1:0]  hit_q, hit_d, miss_q, miss_d, wbn_q, wbn_d;

  // datapath signals
  logic [ADDR_W-1:0]     look_addr;
  logic [OFF_W-1:0]      off;
  logic [SET_W-1:0]      set_sel;
  logic [TAG_W-1:0]      tag_in;
  logic [WAYS*TAG_W-1:0] set_tags, tag_n;
  logic [WAYS-1:0]       set_vld, set_dty, vld_n, dty_n;
  logic [WAYS*AGE_W-1:0] set_age, age_n;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, vic_way, acc_way;
  logic                  accept, hit_acc, miss_acc, fill_done, wb_done, upd_en;
  logic                  we_eff;
  logic [WORD_W-1:0]     wd_eff, rword;
  logic [LINE_W-1:0]     line_n;
  logic [TAG_W-1:0]      vic_tag;
  logic [WAYS*AGE_W*SETS-1:0] age_flat;
  logic [LINES-1:0]      vld_flat, dty_flat;

  assign cpu_ready = (state_q == ST_IDLE);
  assign look_addr = cpu_ready ? cpu_addr : req_addr_q;
  assign off       = look_addr[OFF_W-1:0];
  assign set_sel   = look_addr[OFF_W +: SET_W];
  assign tag_in    = look_addr[ADDR_W-1 -: TAG_W];
  assign set_tags  = tag_q[set_sel];
  assign set_vld   = vld_q[set_sel];
  assign set_dty   = dty_q[set_sel];
  assign set_age   = age_q[set_sel];

  wbc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
    .tags(set_tags), .valid(set_vld), .tag(tag_in), .hit(hit), .hit_way(hit_way)
  );

  wbc_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
    .valid(set_vld), .ages(set_age), .victim(vic_way)
  );

  assign accept    = cpu_req && cpu_ready;
  assign hit_acc   = accept && hit;
  assign miss_acc  = accept && !hit;
  assign fill_done = (state_q == ST_FILL) && mem_ready;
  assign wb_done   = (state_q == ST_WBACK) && mem_ready;
  assign upd_en    = hit_acc || fill_done;
  assign acc_way   = cpu_ready ? hit_way : vic_q;
  assign we_eff    = cpu_ready ? cpu_we : req_we_q;
  assign wd_eff    = cpu_ready ? cpu_wdata : req_wdata_q;

  wbc_age_update #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
    .ages_in(set_age), .acc_way(acc_way), .ages_out(age_n)
  );

  // next line contents and flags for the accessed way
  always_comb begin
    line_n = fill_done ? mem_rdata : line_q[set_sel][acc_way];
    if (we_eff) line_n[int'(off)*WORD_W +: WORD_W] = wd_eff;
    rword  = line_n[int'(off)*WORD_W +: WORD_W];
    tag_n  = set_tags;
    tag_n[int'(acc_way)*TAG_W +: TAG_W] = tag_in;
    vld_n  = set_vld;
    vld_n[acc_way] = 1'b1;
    dty_n  = set_dty;
    if (fill_done)   dty_n[acc_way] = we_eff;
    else if (we_eff) dty_n[acc_way] = 1'b1;
  end

  // next control state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (miss_acc) state_d = (set_vld[vic_way] && set_dty[vic_way]) ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ready) state_d = ST_FILL;
      ST_FILL:  if (mem_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    hit_d  = hit_q  + CNT_W'(hit_acc);
    miss_d = miss_q + CNT_W'(miss_acc);
    wbn_d  = wbn_q  + CNT_W'(wb_done);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      state_q  <= ST_IDLE;
      rvalid_q <= 1'b0;
      hit_q    <= '0;
      miss_q   <= '0;
      wbn_q    <= '0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= upd_en;
      hit_q    <= hit_d;
      miss_q   <= miss_d;
      wbn_q    <= wbn_d;
    end
  end

  // datapath registers without reset, enabled explicitly
  always_ff @(posedge clk) begin
    if (accept) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
    end
    if (miss_acc) vic_q <= vic_way;
    if (upd_en)   rdata_q <= rword;
    if (upd_en) begin
      tag_q[set_sel]           <= tag_n;
      line_q[set_sel][acc_way] <= line_n;
    end
  end

  // line flags with reset
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        age_q[s] <= age_init();
      end
    end else if (upd_en) begin
      vld_q[set_sel] <= vld_n;
      dty_q[set_sel] <= dty_n;
      age_q[set_sel] <= age_n;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_flat
    assign age_flat[s*WAYS*AGE_W +: WAYS*AGE_W] = age_q[s];
    assign vld_flat[s*WAYS +: WAYS] = vld_q[s];
    assign dty_flat[s*WAYS +: WAYS] = dty_q[s];
  end

  wbc_dirty_count #(.LINES(LINES), .CNT_W(CNT_W)) u_dcnt (
    .valid(vld_flat), .dirty(dty_flat), .count(dirty_lines)
  );

  // memory side
  assign vic_tag   = set_tags[int'(vic_q)*TAG_W +: TAG_W];
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = {(mem_we ? vic_tag : tag_in), set_sel, {OFF_W{1'b0}}};
  assign mem_wdata = line_q[set_sel][vic_q];

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;
  assign hit_cnt    = hit_q;
  assign miss_cnt   = miss_q;
  assign wb_cnt     = wbn_q;
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int AGE_W  = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cpu_req,
  input logic                        cpu_ready,
  input logic                        cpu_rvalid,
  input logic                        mem_req,
  input logic                        mem_we,
  input logic                        mem_ready,
  input logic [ADDR_W-1:0]           mem_addr,
  input logic                        hit_acc,
  input logic [CNT_W-1:0]            hit_cnt,
  input logic [CNT_W-1:0]            wb_cnt,
  input logic [SETS*WAYS*AGE_W-1:0]  age_flat
);
  assert_idle_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);

  assert_miss_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && !hit_acc) |=> !cpu_ready);

  assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_wb_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (wb_cnt == CNT_W'($past(wb_cnt) + 1'b1)));

  assert_hit_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc |=> (hit_cnt == CNT_W'($past(hit_cnt) + 1'b1)));

  assert_rvalid_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(hit_acc || (mem_req && !mem_we && mem_ready)));

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0] is_oldest;
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign is_oldest[w] = (age_flat[(s*WAYS+w)*AGE_W +: AGE_W] == AGE_W'(WAYS-1));
    end
    assert_one_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_oldest) == 1);
  end
endmodule

bind wb_cache wbc_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETS(SETS), .WAYS(WAYS), .AGE_W(AGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_q), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .cpu_rvalid(cpu_rvalid), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .hit_acc(hit_acc),
  .hit_cnt(hit_cnt), .wb_cnt(wb_cnt), .age_flat(age_flat)
);

// File: tb/wb_cache_bench.sv
`timescale 1ns/1ps
module wb_cache_bench;
  localparam int BW = 4;
  localparam int LW = BW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0]   cpu_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic          cpu_ready, cpu_rvalid;
  logic [31:0]   cpu_rdata;
  logic          mem_req, mem_we;
  logic [15:0]   mem_addr;
  logic [LW-1:0] mem_wdata;
  logic          mem_ready = 1'b0;
  logic [LW-1:0] mem_rdata = '0;
  logic [15:0]   hit_cnt, miss_cnt, wb_cnt, dirty_lines;

  wb_cache u_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .hit_cnt(hit_cnt),
    .miss_cnt(miss_cnt), .wb_cnt(wb_cnt), .dirty_lines(dirty_lines)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, exp_hit = 0, exp_miss = 0;
  int rd_n = 0, wr_n = 0, seq = 0, rd_seq = 0, wr_seq = 0, nlog = 0;
  logic [15:0]   last_ra, last_wa;
  logic [LW-1:0] last_wd;
  logic [15:0]   log_a [16];
  logic [LW-1:0] log_d [16];
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [15:0] a);
    return {16'h5A5A, a};
  endfunction

  function automatic logic [LW-1:0] blk_val(input logic [15:0] a);
    logic [LW-1:0] v;
    for (int w = 0; w < BW; w++) v[w*32 +: 32] = pat(a + 16'(w));
    for (int i = 0; i < nlog; i++) if (log_a[i] == a) v = log_d[i];
    return v;
  endfunction

  // memory responder: two wait cycles, then a one-cycle ready
  initial begin
    int wt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_req) begin
        if (wt == 2) begin
          wt = 0;
          seq++;
          mem_ready = 1'b1;
          if (mem_we) begin
            wr_n++; wr_seq = seq; last_wa = mem_addr; last_wd = mem_wdata;
            log_a[nlog] = mem_addr; log_d[nlog] = mem_wdata; nlog++;
          end else begin
            rd_n++; rd_seq = seq; last_ra = mem_addr;
            mem_rdata = blk_val(mem_addr);
          end
        end else wt++;
      end
    end
  end

  task automatic cpu_op(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        input bit want_hit, output logic [31:0] rd);
    int lat;
    logic rdy_after;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    rdy_after = cpu_ready;
    lat = 1;
    while (!cpu_rvalid && lat < 200) begin @(negedge clk); lat++; end
    rd = cpu_rdata;
    if (want_hit) begin
      exp_hit++;
      chk(lat == 1 && rdy_after, "R2 hit latency/ready", {lat, rdy_after}, {32'd1, 1'b1});
    end else begin
      exp_miss++;
      chk(!rdy_after && lat > 1 && lat < 200, "R9 miss stall", {lat, rdy_after}, {32'd4, 1'b0});
    end
  endtask

  task automatic t_reset();
    chk(cpu_ready && !mem_req && !cpu_rvalid, "R11 reset handshake",
        {cpu_ready, mem_req, cpu_rvalid}, 3'b100);
    chk(hit_cnt == 0 && miss_cnt == 0 && wb_cnt == 0 && dirty_lines == 0, "R11 reset counters",
        {hit_cnt, miss_cnt, wb_cnt, dirty_lines}, 64'd0);
  endtask

  task automatic t_read_miss_clean();
    logic [31:0] rd;
    int r0 = rd_n, w0 = wr_n;
    cpu_op(1'b0, 16'h0005, '0, 1'b0, rd);
    chk(rd == pat(16'h0005), "R3 miss data", rd, pat(16'h0005));
    chk(rd_n == r0 + 1 && wr_n == w0, "R3 one fill no writeback", {rd_n, wr_n}, {r0 + 1, w0});
    chk(last_ra == 16'h0004, "R1 block base address", last_ra, 16'h0004);
  endtask

  task automatic t_read_hit();
    logic [31:0] rd;
    int r0 = rd_n;
    cpu_op(1'b0, 16'h0006, '0, 1'b1, rd);
    chk(rd == pat(16'h0006) && rd_n == r0, "R2 hit data no traffic", {rd, rd_n}, {pat(16'h0006), r0});
  endtask

  task automatic t_write_hit();
    logic [31:0] rd;
    int r0 = rd_n, w0 = wr_n;
    cpu_op(1'b1, 16'h0007, 32'hDEAD0007, 1'b1, rd);
    chk(rd_n == r0 && wr_n == w0, "R5 write hit no traffic", {rd_n, wr_n}, {r0, w0});
    chk(dirty_lines == 1, "R5 line dirty", dirty_lines, 16'd1);
    cpu_op(1'b0, 16'h0007, '0, 1'b1, rd);
    chk(rd == 32'hDEAD0007, "R5 write hit readback", rd, 32'hDEAD0007);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd;
    int r0 = rd_n;
    cpu_op(1'b1, 16'h0022, 32'hBEEF0022, 1'b0, rd);
    chk(rd_n == r0 + 1 && last_ra == 16'h0020, "R4 allocate fill", {rd_n, last_ra}, {r0 + 1, 16'h0020});
    chk(dirty_lines == 2, "R4 allocated line dirty", dirty_lines, 16'd2);
    cpu_op(1'b0, 16'h0021, '0, 1'b1, rd);
    chk(rd == pat(16'h0021), "R4 neighbour word kept", rd, pat(16'h0021));
    cpu_op(1'b0, 16'h0022, '0, 1'b1, rd);
    chk(rd == 32'hBEEF0022, "R4 merged word", rd, 32'hBEEF0022);
  endtask

  task automatic t_fill_free_way();
    logic [31:0] rd;
    int w0 = wr_n;
    cpu_op(1'b0, 16'h0008, '0, 1'b0, rd);
    cpu_op(1'b0, 16'h0018, '0, 1'b0, rd);
    chk(rd == pat(16'h0018) && wr_n == w0, "R7 second block fills free way", {rd, wr_n}, {pat(16'h0018), w0});
    cpu_op(1'b0, 16'h0008, '0, 1'b1, rd);
    chk(rd == pat(16'h0008), "R7 first block retained", rd, pat(16'h0008));
    cpu_op(1'b0, 16'h0019, '0, 1'b1, rd);
  endtask

  task automatic t_lru_writeback();
    logic [31:0] rd;
    logic [LW-1:0] exp_blk;
    int w0, r0;
    cpu_op(1'b1, 16'h000C, 32'hCAFE000C, 1'b0, rd);
    cpu_op(1'b1, 16'h001C, 32'hCAFE001C, 1'b0, rd);
    chk(dirty_lines == 4, "R10 dirty count after two write misses", dirty_lines, 16'd4);
    cpu_op(1'b0, 16'h000D, '0, 1'b1, rd);
    w0 = wr_n; r0 = rd_n;
    cpu_op(1'b0, 16'h002C, '0, 1'b0, rd);
    exp_blk = blk_val(16'h001C);
    exp_blk = {pat(16'h001F), pat(16'h001E), pat(16'h001D), 32'hCAFE001C};
    chk(wr_n == w0 + 1 && last_wa == 16'h001C, "R8 LRU victim written back", {wr_n, last_wa}, {w0 + 1, 16'h001C});
    chk(last_wd == exp_blk, "R6 writeback block data", last_wd, exp_blk);
    chk(wr_seq < rd_seq && rd_n == r0 + 1 && last_ra == 16'h002C, "R6 writeback before fill",
        {wr_seq, rd_seq, last_ra}, {wr_seq, wr_seq + 1, 16'h002C});
    chk(rd == pat(16'h002C) && wb_cnt == 1, "R6 fill data and wb count", {rd, wb_cnt}, {pat(16'h002C), 16'd1});
    cpu_op(1'b0, 16'h000C, '0, 1'b1, rd);
    chk(rd == 32'hCAFE000C, "R8 recent block kept", rd, 32'hCAFE000C);
    w0 = wr_n;
    cpu_op(1'b0, 16'h001C, '0, 1'b0, rd);
    chk(rd == 32'hCAFE001C && wr_n == w0, "R3 clean victim dropped, refetch", {rd, wr_n}, {32'hCAFE001C, w0});
  endtask

  task automatic t_counters();
    chk(hit_cnt == 16'(exp_hit), "R10 hit count", hit_cnt, 16'(exp_hit));
    chk(miss_cnt == 16'(exp_miss), "R10 miss count", miss_cnt, 16'(exp_miss));
    chk(wb_cnt == 1 && dirty_lines == 3, "R10 wb and dirty count", {wb_cnt, dirty_lines}, {16'd1, 16'd3});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_miss_clean();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_fill_free_way();
    t_lru_writeback();
    repeat (2) @(negedge clk);
    t_counters();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule